// File: doc/BRIEF.md
# Edge-Captured Interrupt Enable and Status Register

This block gathers events from a small set of interrupt sources into one byte-wide register. Each source input is brought into the clock domain through a short flop chain, and a rising edge on a source that is enabled latches a pending bit. A single level interrupt request stays high while any pending bit is set.

The same byte serves for both directions. A write sets the enable mask. A read returns the pending bits. There is no separate acknowledge register. A handler clears a pending event by writing the mask with that source's bit cleared, which drops the pending bit, and then writes the mask back. An event that lands while the source is disabled is lost. A handler that reads the register again after restoring the mask sees any edge that was captured after the restore.

Top module: `irq_evt_reg`

## Requirements
- R1: While reset is held, and after it is released, the enable mask and all pending bits are zero and `irq` is low.
- R2: A write (`sel`=1, `wr`=1) stores `wdata[5:0]` as the enable mask, where bit i enables source i. Bits 7:6 of a write are ignored.
- R3: A rising edge on an enabled source i sets pending bit i. The bit can be read after the third rising clock edge that follows the input's rise: two edges for the synchroniser and one for the capture.
- R4: An edge on a disabled source is not recorded, including after that source is later enabled. A source held high does not set its pending bit again after the bit has been cleared. Only a new low-to-high transition sets it.
- R5: A read (`sel`=1, `wr`=0) returns the pending bits on `rdata[5:0]`, with `rdata[7:6]` always zero. When no read is strobed, `rdata` is all zero.
- R6: Writing a mask whose bit i is 0 clears pending bit i in the cycle of the write. Bit i then reads 0 after it is re-enabled and stays 0 until a new edge arrives. Pending bits of sources that stay enabled are kept.
- R7: Writing zero disables every source and clears every pending bit, so `irq` is low in the next cycle.
- R8: `irq` is a level signal. It is high exactly while at least one pending bit is set.
- R9: An edge whose capture cycle is the same cycle as a write that disables that source is dropped.
- R10: An edge whose capture cycle is the same cycle as a write that enables that source is captured.
- R11: A read leaves the pending bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Register select strobe for one cycle of access |
| wr | input | 1 | 1 = write access, 0 = read access, valid while `sel` is high |
| wdata | input | 8 | Write data; bits 5:0 form the new enable mask |
| rdata | output | 8 | Read data: pending bits in 5:0, zero elsewhere and when not reading |
| src_in | input | 6 | Asynchronous interrupt source lines |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that `sel`, `wr` and `wdata` are driven synchronously, so each access is one clean cycle that the clock sees. They also assume that a source line stays at each level long enough for the two-flop chain to see it. The bench drives every strobe at the falling edge and holds each source level for at least three cycles. For the same-cycle cases it places the write strobe on the exact cycle in which the synchronised edge reaches the capture logic.

// File: rtl/irq_evt_pkg.sv
// Package: shared sizes for the interrupt enable/status register.
// Assumes the source count is smaller than the register width.
package irq_evt_pkg;
    localparam int REG_W_DEF  = 8;
    localparam int NSRC_DEF   = 6;
    localparam int SYNC_DEF   = 2;
endpackage

// File: rtl/irq_evt_sync.sv
// Module: brings asynchronous source lines into the clock domain through a
// flop chain and flags a one-cycle pulse on each synchronised rising edge.
// Assumes each source level is held for at least STAGES+1 cycles.
module irq_evt_sync #(
    parameter int NSRC   = 6,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_in,
    output logic [NSRC-1:0] rise
);
    localparam int LAST = STAGES - 1;

    logic [NSRC-1:0] stg [STAGES];
    logic [NSRC-1:0] prev_q;

    // Shift the source lines through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= src_in;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    // Keep the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stg[LAST];
    end

    // Rising edge is new high level against the stored previous level.
    always_comb rise = stg[LAST] & ~prev_q;
endmodule

// File: rtl/irq_evt_pend.sv
// Module: holds the enable mask and the pending bits. A write replaces the
// mask. A pending bit survives or is set only while its source is enabled
// by the mask in force after the current cycle.
// Assumes wr_stb is a single-cycle synchronous strobe.
module irq_evt_pend #(
    parameter int NSRC = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_stb,
    input  logic [NSRC-1:0] wr_mask,
    input  logic [NSRC-1:0] rise,
    output logic [NSRC-1:0] en_q,
    output logic [NSRC-1:0] pend_q
);
    logic [NSRC-1:0] en_nxt;

    // Choose the mask in force from the next cycle.
    always_comb en_nxt = wr_stb ? wr_mask : en_q;

    // Register the enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_nxt;
    end

    // Per source: capture edges and clear on disable.
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) pend_q[i] <= 1'b0;
            else        pend_q[i] <= en_nxt[i] & (pend_q[i] | rise[i]);
        end
    end
endmodule

// File: rtl/irq_evt_reg.sv
// Module: top of the interrupt enable/status register. Write = enable
// mask, read = pending bits, irq = OR of pending bits.
// Assumes sel/wr/wdata are synchronous and a decoder upstream drives sel.
module irq_evt_reg
    import irq_evt_pkg::*;
#(
    parameter int REG_W       = REG_W_DEF,
    parameter int NSRC        = NSRC_DEF,
    parameter int SYNC_STAGES = SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic [NSRC-1:0]  src_in,
    output logic             irq
);
    logic            wr_stb;
    logic            rd_stb;
    logic [NSRC-1:0] rise;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] pend_q;

    // Decode the access strobes.
    always_comb begin
        wr_stb = sel & wr;
        rd_stb = sel & ~wr;
    end

    irq_evt_sync #(.NSRC(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_in (src_in),
        .rise   (rise)
    );

    irq_evt_pend #(.NSRC(NSRC)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_mask (wdata[NSRC-1:0]),
        .rise    (rise),
        .en_q    (en_q),
        .pend_q  (pend_q)
    );

    // Return pending bits zero-extended on a read, zero otherwise.
    always_comb rdata = rd_stb ? REG_W'(pend_q) : '0;

    // Level request while anything is pending.
    always_comb irq = |pend_q;
endmodule

// File: rtl/irq_evt_chk.sv
// Module: property checker for irq_evt_reg, attached with bind.
// Assumes synchronous access strobes.
module irq_evt_chk #(
    parameter int REG_W = 8,
    parameter int NSRC  = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel,
    input logic             wr,
    input logic [REG_W-1:0] wdata,
    input logic [REG_W-1:0] rdata,
    input logic             irq,
    input logic [NSRC-1:0]  en_q,
    input logic [NSRC-1:0]  pend_q
);
    p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[REG_W-1:NSRC] == '0);

    p_idle_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && !wr) |-> rdata == '0);

    p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr) |-> (irq == (rdata != '0)));

    p_disable_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr) |=> ((pend_q & ~$past(wdata[NSRC-1:0])) == '0));

    p_zero_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && wdata[NSRC-1:0] == '0) |=> !irq);

    p_read_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    p_mask_stored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr) |=> en_q == $past(wdata[NSRC-1:0]));
endmodule

bind irq_evt_reg irq_evt_chk #(.REG_W(REG_W), .NSRC(NSRC)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (sel),
    .wr     (wr),
    .wdata  (wdata),
    .rdata  (rdata),
    .irq    (irq),
    .en_q   (en_q),
    .pend_q (pend_q)
);

// File: tb/tb_irq_evt_reg.sv
`timescale 1ns/1ps
module tb_irq_evt_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [5:0] src_in = '0;
    logic       irq;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    irq_evt_reg dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .wdata(wdata),
        .rdata(rdata), .src_in(src_in), .irq(irq)
    );

    // {enable written, source pulses, expected status}
    localparam logic [17:0] VEC [6] = '{
        {6'h3F, 6'h01, 6'h01},
        {6'h3F, 6'h2A, 6'h2A},
        {6'h15, 6'h3F, 6'h15},
        {6'h0A, 6'h2F, 6'h0A},
        {6'h20, 6'h20, 6'h20},
        {6'h00, 6'h3F, 6'h00}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [7:0] v);
        sel = 1'b1; wr = 1'b1; wdata = v;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    task automatic rreg(output logic [7:0] v, output logic q);
        sel = 1'b1; wr = 1'b0;
        #1 v = rdata; q = irq;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic pulse(input logic [5:0] m);
        src_in = m;
        repeat (3) @(negedge clk);
        src_in = '0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic       q;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rreg(v, q);
        chk("R1 status after reset", v, 8'h00);
        chk("R1 irq after reset", {7'd0, q}, 8'h00);

        // R3 R8: vector walk
        foreach (VEC[n]) begin
            wreg({2'b00, VEC[n][17:12]});
            pulse(VEC[n][11:6]);
            rreg(v, q);
            chk($sformatf("R3 vector %0d status", n), v, {2'b00, VEC[n][5:0]});
            chk($sformatf("R8 vector %0d irq", n), {7'd0, q}, {7'd0, VEC[n][5:0] != 0});
            wreg(8'h00);
        end

        // R2: upper write bits ignored, upper read bits zero
        wreg(8'hFF);
        pulse(6'h3F);
        rreg(v, q);
        chk("R2 upper bits ignored", v, 8'h3F);
        // R5: no strobe gives zero
        #1 chk("R5 idle rdata zero", rdata, 8'h00);
        @(negedge clk);
        // R7: zero write clears everything
        wreg(8'h00);
        #1 chk("R7 irq after zero write", {7'd0, irq}, 8'h00);
        @(negedge clk);
        rreg(v, q);
        chk("R7 status after zero write", v, 8'h00);

        // R4: edge while disabled is not kept
        pulse(6'h01);
        wreg(8'h01);
        rreg(v, q);
        chk("R4 disabled edge lost", v, 8'h00);
        // R4: held level does not re-set after ack
        src_in = 6'h01;
        repeat (4) @(negedge clk);
        rreg(v, q);
        chk("R4 held source first edge", v, 8'h01);
        wreg(8'h00);
        wreg(8'h01);
        repeat (5) @(negedge clk);
        rreg(v, q);
        chk("R4 held level no re-set", v, 8'h00);
        src_in = '0;
        repeat (3) @(negedge clk);

        // R6 R11: selective acknowledge
        wreg(8'h03);
        pulse(6'h03);
        wreg(8'h02);
        rreg(v, q);
        chk("R6 other bit kept", v, 8'h02);
        chk("R8 irq still high", {7'd0, q}, 8'h01);
        wreg(8'h03);
        rreg(v, q);
        chk("R6 re-enabled bit stays clear", v, 8'h02);
        rreg(v, q);
        chk("R11 read keeps pending", v, 8'h02);
        wreg(8'h00);

        // R9: edge in same cycle as disabling write is dropped
        wreg(8'h01);
        src_in = 6'h01;
        @(negedge clk);
        @(negedge clk);
        wreg(8'h00);
        wreg(8'h01);
        rreg(v, q);
        chk("R9 coincident disable drops edge", v, 8'h00);
        src_in = '0;
        repeat (3) @(negedge clk);
        wreg(8'h00);

        // R10: edge in same cycle as enabling write is captured
        src_in = 6'h04;
        @(negedge clk);
        @(negedge clk);
        wreg(8'h04);
        rreg(v, q);
        chk("R10 coincident enable captures edge", v, 8'h04);
        src_in = '0;

        // R1: reset mid-run clears pending
        rst_n = 1'b0;
        @(negedge clk);
        #1 chk("R1 irq during reset", {7'd0, irq}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rreg(v, q);
        chk("R1 status after second reset", v, 8'h00);
        pulse(6'h3F);
        rreg(v, q);
        chk("R1 mask zero after reset", v, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule